// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Transmitter

This block takes a stereo stream from a three-wire serial audio source (bit clock, frame sync and data) and turns it into a self-clocking biphase-mark line signal of the consumer digital audio kind. A deserializer accepts left-justified, I2S or right-justified framing with 16, 18, 20 or 24-bit words. It keeps the most recent complete sample of each channel in a holding register.

A line encoder runs from a half-cell enable that pulses at twice the cell rate. It emits 64 half-cells per subframe and alternates between left and right subframes. At the start of each subframe it takes the latest sample for that channel and builds a 32-slot word: a sync preamble, a 24-bit audio field, validity, user, channel-status and parity slots. The channel-status bit comes from a 192-bit input vector, indexed by a frame counter that wraps every 192 frames.

All inputs, including the serial audio wires, are sampled by the single system clock. The bit clock must be slower than half the system clock rate.

Top module: `spdif_tx`

## Requirements
- R1: During reset and right after it, `spdifOut` is low. The first subframe after reset is a left subframe of frame 0, with a B preamble and all of slots 4 to 31 zero.
- R2: Serial bits are sampled on rising edges of `bitClk`. Any change of `frameSync` between two rising edges starts a new channel slot. With `fmtSel`=0 (left-justified) the MSB is the first bit of the slot, and `frameSync` high marks the left channel.
- R3: With `fmtSel`=1 (I2S) the MSB is the second bit of the slot, and `frameSync` low marks the left channel.
- R4: With `fmtSel`=2 (right-justified) the LSB is bit 31 of a 32-bit slot, and `frameSync` high marks the left channel.
- R5: `widthSel` 0/1/2/3 selects 16/18/20/24-bit words. Slot bits outside the word are ignored. A word is placed MSB-first at the top of the 24-bit audio field, and its unused low bits are zero.
- R6: `spdifOut` moves by one half-cell per cycle with `halfCellEn` high and holds its level otherwise. Each data cell starts with a transition. A cell carrying 1 has a second transition at mid-cell; a cell carrying 0 has none.
- R7: A subframe is 64 half-cells: slots 0-3 preamble, 4-27 audio LSB first, 28 `validFlag`, 29 `userFlag`, 30 channel status, 31 parity. Subframes alternate left and right. Sample and flags are taken when the previous subframe's last half-cell is sent.
- R8: Preambles, as half-cell levels after a low line: B = 11101000, M = 11100010, W = 11100100. After a high line they are inverted. B starts left subframes of frame 0, M starts the other left subframes, and W starts right subframes.
- R9: Slot 31 makes the count of ones in slots 4 to 31 even, so the line is low at every subframe boundary.
- R10: Slot 30 carries `chanStatus[frame]`. The frame index advances after each right subframe and wraps from 191 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Serial audio bit clock, sampled by `clk` |
| frameSync | input | 1 | Serial audio frame sync (channel select) |
| serData | input | 1 | Serial audio data |
| fmtSel | input | 2 | 0 left-justified, 1 I2S, 2 right-justified |
| widthSel | input | 2 | 0/1/2/3 = 16/18/20/24-bit words |
| halfCellEn | input | 1 | Line-rate strobe, one per half-cell |
| validFlag | input | 1 | Value for the validity slot |
| userFlag | input | 1 | Value for the user slot |
| chanStatus | input | 192 | Channel-status block, one bit per frame |
| spdifOut | output | 1 | Biphase-mark coded line output |

## Verification
The checker counts `halfCellEn` pulses since reset to locate the subframe boundaries. It assumes that reset is the only event that realigns the encoder. It also assumes that `halfCellEn` is the sole thing that advances the line. The properties on preamble shape, cell-start transitions and boundary polarity rely only on that count, so the bench may drive any audio pattern. The bench always drives `bitClk` with both phases at least one system clock long. It changes `frameSync` and `serData` only while `bitClk` is low. It changes format and width only between frames. It also runs a phase where `halfCellEn` pulses on every other cycle, so the hold behaviour is checked with gaps.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

  localparam int AUDIO_BITS = 24;
  localparam int SUB_SLOTS  = 32;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_I2S = 2'd1,
    FMT_RJ  = 2'd2
  } fmt_e;

  typedef enum logic [1:0] {
    PRE_B = 2'd0,
    PRE_M = 2'd1,
    PRE_W = 2'd2
  } pre_e;

  typedef struct packed {
    logic       shiftEn;
    logic       storeLeft;
    logic       storeRight;
    logic       step;
    logic       loadSub;
    logic       loadRight;
    logic [5:0] halfIdx;
    pre_e       pre;
  } ctrl_strobe_t;

  function automatic int wordBits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  // Transitions per preamble half-cell, first half-cell in bit 7
  function automatic logic [7:0] preToggles(input pre_e p);
    case (p)
      PRE_B:   return 8'b1001_1100;
      PRE_M:   return 8'b1001_0011;
      default: return 8'b1001_0110;
    endcase
  endfunction

endpackage

// File: rtl/spdif_tx_ctrl.sv
module spdif_tx_ctrl
  import spdif_tx_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int FRAMES    = 192,
  localparam int IDX_W    = $clog2(SLOT_BITS) + 1,
  localparam int FRM_W    = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitClk,
  input  logic             frameSync,
  input  logic [1:0]       fmtSel,
  input  logic [1:0]       widthSel,
  input  logic             halfCellEn,
  output ctrl_strobe_t     strb,
  output logic [FRM_W-1:0] loadFrame
);

  logic             prevBitClk;
  logic             prevFs;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] nextIdx;
  logic [5:0]       halfIdx;
  logic             isRight;
  logic [FRM_W-1:0] frameIdx;
  logic [FRM_W-1:0] frameNext;
  logic             bitRise;
  logic             inWord;
  logic             lastBit;
  logic             leftSlot;
  int               idxI;
  int               startI;
  int               lenI;

  // ---------------- input slot tracking ----------------
  always_comb begin
    bitRise  = bitClk & ~prevBitClk;
    if (frameSync != prevFs)
      nextIdx = '0;
    else if (bitIdx == '1)
      nextIdx = bitIdx;
    else
      nextIdx = bitIdx + 1'b1;
    idxI = int'(nextIdx);
    lenI = wordBits(widthSel);
    case (fmtSel)
      FMT_I2S: startI = 1;
      FMT_RJ:  startI = SLOT_BITS - lenI;
      default: startI = 0;
    endcase
    inWord   = (idxI >= startI) && (idxI < startI + lenI);
    lastBit  = bitRise && (idxI == startI + lenI - 1);
    leftSlot = (fmtSel == FMT_I2S) ? ~frameSync : frameSync;
  end

  // ---------------- encoder sequencing ----------------
  always_comb begin
    if (!isRight)
      frameNext = frameIdx;
    else if (frameIdx == FRM_W'(FRAMES - 1))
      frameNext = '0;
    else
      frameNext = frameIdx + 1'b1;
    loadFrame = frameNext;

    strb.shiftEn    = bitRise & inWord;
    strb.storeLeft  = lastBit & leftSlot;
    strb.storeRight = lastBit & ~leftSlot;
    strb.step       = halfCellEn;
    strb.loadSub    = halfCellEn && (halfIdx == 6'd63);
    strb.loadRight  = ~isRight;
    strb.halfIdx    = halfIdx;
    if (isRight)
      strb.pre = PRE_W;
    else if (frameIdx == '0)
      strb.pre = PRE_B;
    else
      strb.pre = PRE_M;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBitClk <= 1'b0;
      prevFs     <= 1'b0;
      bitIdx     <= '1;
      halfIdx    <= '0;
      isRight    <= 1'b0;
      frameIdx   <= '0;
    end else begin
      prevBitClk <= bitClk;
      if (bitRise) begin
        prevFs <= frameSync;
        bitIdx <= nextIdx;
      end
      if (halfCellEn) begin
        halfIdx <= halfIdx + 1'b1;
        if (halfIdx == 6'd63) begin
          isRight  <= ~isRight;
          frameIdx <= frameNext;
        end
      end
    end
  end

endmodule

// File: rtl/spdif_tx_dp.sv
module spdif_tx_dp
  import spdif_tx_pkg::*;
#(
  parameter int FRAMES = 192,
  localparam int FRM_W = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serData,
  input  logic [1:0]        widthSel,
  input  logic              validFlag,
  input  logic              userFlag,
  input  logic [FRAMES-1:0] chanStatus,
  input  ctrl_strobe_t      strb,
  input  logic [FRM_W-1:0]  loadFrame,
  output logic              spdifOut
);

  logic [AUDIO_BITS-1:0] shiftReg;
  logic [AUDIO_BITS-1:0] shiftNext;
  logic [AUDIO_BITS-1:0] aligned;
  logic [AUDIO_BITS-1:0] leftHold;
  logic [AUDIO_BITS-1:0] rightHold;
  logic [AUDIO_BITS-1:0] sample;
  logic [SUB_SLOTS-1:0]  slotBits;
  logic [SUB_SLOTS-1:0]  newSlots;
  logic [AUDIO_BITS+2:0] payload;
  logic                  csBit;
  logic                  toggle;
  logic [7:0]            preVec;
  logic                  lineQ;

  always_comb begin
    shiftNext = {shiftReg[AUDIO_BITS-2:0], serData};
    aligned   = shiftNext << (AUDIO_BITS - wordBits(widthSel));
    sample    = strb.loadRight ? rightHold : leftHold;
    csBit     = chanStatus[loadFrame];
    payload   = {csBit, userFlag, validFlag, sample};
    newSlots  = {^payload, payload, 4'b0000};
    preVec    = preToggles(strb.pre);
    if (strb.halfIdx < 6'd8)
      toggle = preVec[3'd7 - strb.halfIdx[2:0]];
    else if (!strb.halfIdx[0])
      toggle = 1'b1;
    else
      toggle = slotBits[strb.halfIdx[5:1]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      leftHold  <= '0;
      rightHold <= '0;
      slotBits  <= '0;
      lineQ     <= 1'b0;
    end else begin
      if (strb.shiftEn)    shiftReg  <= shiftNext;
      if (strb.storeLeft)  leftHold  <= aligned;
      if (strb.storeRight) rightHold <= aligned;
      if (strb.loadSub)    slotBits  <= newSlots;
      if (strb.step)       lineQ     <= lineQ ^ toggle;
    end
  end

  assign spdifOut = lineQ;

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_tx_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int FRAMES    = 192,
  localparam int FRM_W    = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              frameSync,
  input  logic              serData,
  input  logic [1:0]        fmtSel,
  input  logic [1:0]        widthSel,
  input  logic              halfCellEn,
  input  logic              validFlag,
  input  logic              userFlag,
  input  logic [FRAMES-1:0] chanStatus,
  output logic              spdifOut
);

  ctrl_strobe_t     strb;
  logic [FRM_W-1:0] loadFrame;

  spdif_tx_ctrl #(.SLOT_BITS(SLOT_BITS), .FRAMES(FRAMES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitClk     (bitClk),
    .frameSync  (frameSync),
    .fmtSel     (fmtSel),
    .widthSel   (widthSel),
    .halfCellEn (halfCellEn),
    .strb       (strb),
    .loadFrame  (loadFrame)
  );

  spdif_tx_dp #(.FRAMES(FRAMES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .serData    (serData),
    .widthSel   (widthSel),
    .validFlag  (validFlag),
    .userFlag   (userFlag),
    .chanStatus (chanStatus),
    .strb       (strb),
    .loadFrame  (loadFrame),
    .spdifOut   (spdifOut)
  );

endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk (
  input logic clk,
  input logic rstN,
  input logic halfCellEn,
  input logic spdifOut
);

  logic [5:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN)           stepCnt <= '0;
    else if (halfCellEn) stepCnt <= stepCnt + 1'b1;
  end

  // R1
  always @(posedge clk) begin
    if (!rstN) reset_line_low_chk: assert (spdifOut == 1'b0 || $time == 0);
  end

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !halfCellEn |=> $stable(spdifOut));

  // R6
  cell_start_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfCellEn && stepCnt >= 6'd8 && !stepCnt[0]) |=> (spdifOut != $past(spdifOut)));

  // R9
  boundary_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfCellEn && stepCnt == 6'd0) |-> (spdifOut == 1'b0));

  // R8
  preamble_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfCellEn && stepCnt == 6'd0) |=> (spdifOut != $past(spdifOut)));

  // R8
  preamble_flat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfCellEn && (stepCnt == 6'd1 || stepCnt == 6'd2)) |=> $stable(spdifOut));

  // R8
  preamble_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfCellEn && stepCnt == 6'd3) |=> (spdifOut != $past(spdifOut)));

endmodule

bind spdif_tx spdif_tx_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .halfCellEn (halfCellEn),
  .spdifOut   (spdifOut)
);

// File: tb/tb_spdif_tx.sv
module tb_spdif_tx;

  localparam int CLK_PERIOD = 10;
  localparam int FRAMES     = 192;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              bitClk = 1'b0;
  logic              frameSync = 1'b0;
  logic              serData = 1'b0;
  logic [1:0]        fmtSel = 2'd0;
  logic [1:0]        widthSel = 2'd0;
  logic              halfCellEn = 1'b0;
  logic              validFlag = 1'b0;
  logic              userFlag = 1'b0;
  logic [FRAMES-1:0] chanStatus = '0;
  logic              spdifOut;

  spdif_tx #(.SLOT_BITS(32), .FRAMES(FRAMES)) dut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameSync(frameSync),
    .serData(serData), .fmtSel(fmtSel), .widthSel(widthSel),
    .halfCellEn(halfCellEn), .validFlag(validFlag), .userFlag(userFlag),
    .chanStatus(chanStatus), .spdifOut(spdifOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    nChecks = 0;
  int    nFail = 0;
  string curTag = "R1 reset";
  bit    comparing = 0;
  bit    gapMode = 0;
  int    cycles = 0;

  // ---------------- behavioural reference ----------------
  bit mLine;
  bit mQ[$];
  bit mBits[$];
  bit mIsRight;
  int mFrame;
  int mIdx;
  bit mPrevClk;
  bit mPrevFs;
  int mLeft;
  int mRight;

  function automatic int widthOf(input logic [1:0] s);
    case (s) 2'd0: return 16; 2'd1: return 18; 2'd2: return 20; default: return 24; endcase
  endfunction

  function automatic int startOf(input logic [1:0] f, input int w);
    if (f == 2'd1) return 1;
    if (f == 2'd2) return 32 - w;
    return 0;
  endfunction

  function automatic void buildSub(input bit lvl, input int kind, input int smp,
                                   input bit v, input bit u, input bit c);
    bit [7:0] pat;
    bit slots[28];
    bit last;
    bit par;
    bit a;
    pat = (kind == 0) ? 8'hE8 : (kind == 1) ? 8'hE2 : 8'hE4;
    for (int k = 0; k < 8; k++) mQ.push_back(pat[7-k] ^ lvl);
    par = 0;
    for (int k = 0; k < 24; k++) slots[k] = smp[k];
    slots[24] = v; slots[25] = u; slots[26] = c;
    for (int k = 0; k < 27; k++) par ^= slots[k];
    slots[27] = par;
    last = lvl;
    for (int k = 0; k < 28; k++) begin
      a = ~last;
      mQ.push_back(a);
      last = slots[k] ? ~a : a;
      mQ.push_back(last);
    end
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mLine = 0; mQ.delete(); mBits.delete();
      buildSub(1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
      mIsRight = 0; mFrame = 0; mIdx = 1000;
      mPrevClk = 0; mPrevFs = 0; mLeft = 0; mRight = 0;
    end else begin
      if (halfCellEn) begin
        mLine = mQ.pop_front();
        if (mQ.size() == 0) begin
          if (mIsRight) mFrame = (mFrame + 1) % FRAMES;
          mIsRight = !mIsRight;
          buildSub(mLine, mIsRight ? 2 : (mFrame == 0 ? 0 : 1),
                   mIsRight ? mRight : mLeft, validFlag, userFlag, chanStatus[mFrame]);
        end
      end
      if (bitClk && !mPrevClk) begin
        int w;
        int st;
        int val;
        if (frameSync != mPrevFs) begin mIdx = 0; mBits.delete(); end
        else mIdx++;
        mPrevFs = frameSync;
        w  = widthOf(widthSel);
        st = startOf(fmtSel, w);
        if (mIdx >= st && mIdx < st + w) mBits.push_back(serData);
        if (mIdx == st + w - 1) begin
          val = 0;
          foreach (mBits[k]) val = (val << 1) | int'(mBits[k]);
          val = (val << (24 - w)) & 24'hFFFFFF;
          if ((fmtSel == 2'd1) ? !frameSync : frameSync) mLeft = val; else mRight = val;
          mBits.delete();
        end
      end
      mPrevClk = bitClk;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (comparing && rstN) begin
      check(spdifOut == mLine, curTag, int'(spdifOut), int'(mLine));
      if (mQ.size() == 64)
        check(spdifOut == 1'b0, "R9 boundary level", int'(spdifOut), 0);
    end
  end

  always @(negedge clk) if (gapMode) halfCellEn = ~halfCellEn;

  // ---------------- stimulus ----------------
  task automatic sendFrame(input int l, input int r, input bit padBit);
    int w;
    int st;
    bit leftLvl;
    int smp;
    w = widthOf(widthSel);
    st = startOf(fmtSel, w);
    leftLvl = (fmtSel == 2'd1) ? 1'b0 : 1'b1;
    for (int ch = 0; ch < 2; ch++) begin
      smp = (ch == 0) ? l : r;
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        bitClk = 1'b0;
        frameSync = (ch == 0) ? leftLvl : ~leftLvl;
        serData = (i >= st && i < st + w) ? smp[w-1-(i-st)] : padBit;
        @(negedge clk);
        bitClk = 1'b1;
      end
    end
  endtask

  task automatic runPhase(input string tag, input logic [1:0] f, input logic [1:0] ws,
                          input int nFrames);
    int w;
    @(negedge clk);
    curTag = tag; fmtSel = f; widthSel = ws;
    w = widthOf(ws);
    for (int n = 0; n < nFrames; n++)
      sendFrame(int'($urandom) & ((1 << w) - 1), int'($urandom) & ((1 << w) - 1), n[0]);
  endtask

  initial begin
    bit [7:0] bPat;
    for (int k = 0; k < FRAMES; k++) chanStatus[k] = 1'($urandom);
    repeat (4) @(negedge clk);
    check(spdifOut == 1'b0, "R1 reset level", int'(spdifOut), 0);
    rstN = 1'b1;
    halfCellEn = 1'b1;
    bPat = 8'hE8;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(spdifOut == bPat[7-k], "R1 R8 first B preamble", int'(spdifOut), int'(bPat[7-k]));
    end
    comparing = 1;
    runPhase("R2 left-justified 16-bit", 2'd0, 2'd0, 4);
    runPhase("R2 R5 left-justified 24-bit", 2'd0, 2'd3, 4);
    runPhase("R3 I2S 18-bit", 2'd1, 2'd1, 4);
    runPhase("R3 R5 I2S 24-bit", 2'd1, 2'd3, 4);
    runPhase("R4 right-justified 20-bit", 2'd2, 2'd2, 4);
    runPhase("R4 R5 right-justified 16-bit", 2'd2, 2'd0, 4);
    @(negedge clk); validFlag = 1'b1; userFlag = 1'b1;
    runPhase("R7 flag slots", 2'd0, 2'd3, 3);
    @(negedge clk); validFlag = 1'b0;
    gapMode = 1;
    runPhase("R6 gapped half-cell enable", 2'd1, 2'd2, 4);
    gapMode = 0;
    @(negedge clk); halfCellEn = 1'b1; userFlag = 1'b0;
    runPhase("R8 R10 block wrap", 2'd0, 2'd3, 200);
    repeat (200) @(negedge clk);
    comparing = 0;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule